// File: doc/BRIEF.md
# Event-Credited Counting Semaphore Unit

This block lets external signals wake tasks without any interrupt. Each event input is sampled and watched for a rising edge. When an edge is seen, the block credits a programmable number of units to a programmable counting semaphore. If the chosen target lives in another processor, the block forwards the credit on a separate output and leaves the local semaphore alone.

Tasks talk to the block through one request port. A wait request places the task number at the tail of the semaphore's waiting queue. A signal request adds a single unit.

Whenever a semaphore holds at least one unit and has a waiting task, the block releases the task at the head of that queue and removes one unit. The released task number and its semaphore appear on the release output for one cycle. A scheduler elsewhere picks the released task up from there.

Top module: `evsem_unit`

## Requirements
- R1: After reset, `rel_valid`, `fwd_valid` and `ovf_flag` are 0, every count is 0, every waiting queue is empty, and every event is configured as local, targeting semaphore 0 with 0 units.
- R2: Each event input passes through two synchronising flip-flops. Only a low-to-high change counts as activity: a level held high counts once, and a falling edge counts as nothing.
- R3: A write with `cfg_we`=1 stores `cfg_remote`, `cfg_sem` and `cfg_units` for event `cfg_evt`. When a local event is served, its unit count is added to its target semaphore.
- R4: When a remote event is served, `fwd_valid` pulses for one cycle with that event's `fwd_sem` and `fwd_units`, and no local count changes. If an input first reads high at clock edge 1, the pulse is visible after edge 4.
- R5: Each input has a pending bit, so no event is lost. Pending events are served one per cycle, lowest input index first.
- R6: Each semaphore has a first-in first-out queue of QDEPTH task numbers. A wait request (`req_signal`=0) to a full queue is dropped.
- R7: When a semaphore's count is at least 1 and its queue is not empty, the oldest waiter is released and the count drops by 1. The release appears on `rel_valid`/`rel_sem`/`rel_task` one edge after the edge at which both conditions first hold.
- R8: At most one task is released per cycle. When several semaphores are eligible at once, the lowest semaphore index goes first.
- R9: A signal request (`req_signal`=1) adds one unit at the edge that captures it. An event credit and a signal landing on the same edge both count.
- R10: A count saturates at 65535 instead of wrapping. The semaphore's bit in `ovf_flag` is then set and stays set until reset. A sum of exactly 65535 does not set the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | External event inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_evt | input | clog2(NUM_EVT) | Event being configured |
| cfg_remote | input | 1 | Target semaphore is in another processor |
| cfg_sem | input | clog2(NUM_SEM) | Target semaphore index |
| cfg_units | input | UNIT_W | Units credited per event |
| req_valid | input | 1 | Task request present |
| req_signal | input | 1 | 1 = signal (add a unit), 0 = wait |
| req_sem | input | clog2(NUM_SEM) | Semaphore addressed by the request |
| req_task | input | TASK_W | Task number of a wait request |
| rel_valid | output | 1 | A task is released this cycle |
| rel_sem | output | clog2(NUM_SEM) | Semaphore of the released task |
| rel_task | output | TASK_W | Released task number |
| fwd_valid | output | 1 | Remote credit to forward |
| fwd_sem | output | clog2(NUM_SEM) | Remote semaphore index |
| fwd_units | output | UNIT_W | Remote unit count |
| ovf_flag | output | NUM_SEM | Sticky saturation flag per semaphore |

## Verification
The bench raises all four inputs in one cycle and expects four forwarded credits in consecutive cycles, in index order.
- A design without pending bits would drop three of them.
- A design with the wrong priority would reorder them.
- A design that is level-sensitive would keep firing while the inputs stay high.

It overfills a wait queue and then reads the release log to confirm that the extra task never comes out and that the others leave in arrival order. It makes an event credit and a signal land on one edge, both on the same semaphore and on two different semaphores. A design that drops one of the two increments would release too few tasks, and one with the wrong release priority would release them in the wrong order. Finally, it drives a count to exactly 65535 and then one credit past it, which catches an off-by-one in the overflow compare and any flag that clears itself.

// File: rtl/evsem_pkg.sv
package evsem_pkg;
  typedef enum logic {
    OP_WAIT   = 1'b0,
    OP_SIGNAL = 1'b1
  } sem_op_e;
endpackage

// File: rtl/evsem_front.sv
module evsem_front #(
  parameter int NUM_EVT = 4,
  localparam int EVT_IW = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [NUM_EVT-1:0] rise,
  output logic [NUM_EVT-1:0] pend,
  output logic [NUM_EVT-1:0] grant,
  output logic               grant_vld,
  output logic [EVT_IW-1:0]  grant_idx
);
  logic [NUM_EVT-1:0] s1_q, s2_q, prev_q, pend_q, pend_d;

  // two-stage synchroniser plus a previous-value register for edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      s1_q   <= evt_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign rise = s2_q & ~prev_q;

  // lowest pending index wins
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = EVT_IW'(i);
      end
    end
    grant_vld = |pend_q;
    pend_d    = (pend_q & ~grant) | rise;
  end

  assign pend = pend_q;
endmodule

// File: rtl/evsem_fifo.sv
module evsem_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (PW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push != do_pop) cnt_q <= do_push ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/evsem_unit.sv
module evsem_unit
  import evsem_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int NUM_SEM = 4,
  parameter int TASK_W  = 4,
  parameter int QDEPTH  = 4,
  parameter int CNT_W   = 16,
  parameter int UNIT_W  = 8,
  localparam int EVT_IW = $clog2(NUM_EVT),
  localparam int SEM_IW = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               cfg_we,
  input  logic [EVT_IW-1:0]  cfg_evt,
  input  logic               cfg_remote,
  input  logic [SEM_IW-1:0]  cfg_sem,
  input  logic [UNIT_W-1:0]  cfg_units,
  input  logic               req_valid,
  input  logic               req_signal,
  input  logic [SEM_IW-1:0]  req_sem,
  input  logic [TASK_W-1:0]  req_task,
  output logic               rel_valid,
  output logic [SEM_IW-1:0]  rel_sem,
  output logic [TASK_W-1:0]  rel_task,
  output logic               fwd_valid,
  output logic [SEM_IW-1:0]  fwd_sem,
  output logic [UNIT_W-1:0]  fwd_units,
  output logic [NUM_SEM-1:0] ovf_flag
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] CNT_MAX = {2'b00, {CNT_W{1'b1}}};

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s_n, rst_m_q} <= 2'b00;
    else        {rst_s_n, rst_m_q} <= {rst_m_q, 1'b1};
  end

  sem_op_e req_op;
  assign req_op = sem_op_e'(req_signal);

  // per-event configuration
  logic [NUM_EVT-1:0] cfg_rem_q;
  logic [SEM_IW-1:0]  cfg_sem_q  [NUM_EVT];
  logic [UNIT_W-1:0]  cfg_unit_q [NUM_EVT];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_rem_q <= '0;
      for (int i = 0; i < NUM_EVT; i++) begin
        cfg_sem_q[i]  <= '0;
        cfg_unit_q[i] <= '0;
      end
    end else if (cfg_we) begin
      cfg_rem_q[cfg_evt]  <= cfg_remote;
      cfg_sem_q[cfg_evt]  <= cfg_sem;
      cfg_unit_q[cfg_evt] <= cfg_units;
    end
  end

  // event front end
  logic [NUM_EVT-1:0] evt_rise, evt_pend, evt_grant;
  logic               g_vld;
  logic [EVT_IW-1:0]  g_idx;

  evsem_front #(.NUM_EVT(NUM_EVT)) u_front (
    .clk(clk), .rst_n(rst_s_n), .evt_in(evt_in),
    .rise(evt_rise), .pend(evt_pend), .grant(evt_grant),
    .grant_vld(g_vld), .grant_idx(g_idx)
  );

  logic              sel_rem;
  logic [SEM_IW-1:0] sel_sem;
  logic [UNIT_W-1:0] sel_units;
  assign sel_rem   = cfg_rem_q[g_idx];
  assign sel_sem   = cfg_sem_q[g_idx];
  assign sel_units = cfg_unit_q[g_idx];

  // forward path for remote targets
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      fwd_valid <= 1'b0;
      fwd_sem   <= '0;
      fwd_units <= '0;
    end else begin
      fwd_valid <= g_vld & sel_rem;
      if (g_vld & sel_rem) begin
        fwd_sem   <= sel_sem;
        fwd_units <= sel_units;
      end
    end
  end

  // semaphores: count, queue, overflow
  logic [NUM_SEM-1:0] cnt_nz, q_empty, q_full, q_pop, q_push, sat_hit;
  logic [TASK_W-1:0]  q_head [NUM_SEM];
  logic               rel_go;
  logic [SEM_IW-1:0]  rel_pick;

  always_comb begin
    rel_go   = 1'b0;
    rel_pick = '0;
    for (int s = NUM_SEM - 1; s >= 0; s--) begin
      if (cnt_nz[s] && !q_empty[s]) begin
        rel_go   = 1'b1;
        rel_pick = SEM_IW'(s);
      end
    end
  end

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SUM_W-1:0] sum;

    assign q_pop[s]  = rel_go && (rel_pick == SEM_IW'(s));
    assign q_push[s] = req_valid && (req_op == OP_WAIT) && (req_sem == SEM_IW'(s));

    always_comb begin
      sum = {2'b00, cnt_q};
      if (g_vld && !sel_rem && sel_sem == SEM_IW'(s)) sum = sum + SUM_W'(sel_units);
      if (req_valid && req_op == OP_SIGNAL && req_sem == SEM_IW'(s)) sum = sum + 1'b1;
      if (q_pop[s]) sum = sum - 1'b1;
      sat_hit[s] = (sum > CNT_MAX);
      cnt_d      = sat_hit[s] ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) begin
        cnt_q       <= '0;
        ovf_flag[s] <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        if (sat_hit[s]) ovf_flag[s] <= 1'b1;
      end
    end

    assign cnt_nz[s] = (cnt_q != '0);

    evsem_fifo #(.DEPTH(QDEPTH), .W(TASK_W)) u_q (
      .clk(clk), .rst_n(rst_s_n), .push(q_push[s]), .din(req_task),
      .pop(q_pop[s]), .dout(q_head[s]), .empty(q_empty[s]), .full(q_full[s])
    );
  end

  // release output
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rel_valid <= 1'b0;
      rel_sem   <= '0;
      rel_task  <= '0;
    end else begin
      rel_valid <= rel_go;
      if (rel_go) begin
        rel_sem  <= rel_pick;
        rel_task <= q_head[rel_pick];
      end
    end
  end
endmodule

// File: rtl/evsem_unit_chk.sv
module evsem_unit_chk #(
  parameter int NUM_EVT = 4,
  parameter int NUM_SEM = 4,
  parameter int SEM_IW  = 2
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic [NUM_EVT-1:0] evt_rise,
  input logic [NUM_EVT-1:0] evt_pend,
  input logic [NUM_EVT-1:0] evt_grant,
  input logic               rel_valid,
  input logic [SEM_IW-1:0]  rel_sem,
  input logic [NUM_SEM-1:0] cnt_nz,
  input logic               fwd_valid,
  input logic [NUM_SEM-1:0] ovf_flag
);
  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(evt_grant));

  assert_edge_kept_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (evt_rise != '0) |=> ((evt_pend & $past(evt_rise)) == $past(evt_rise)));

  assert_release_has_unit_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    rel_valid |-> ((($past(cnt_nz) >> rel_sem) & NUM_SEM'(1)) != '0));

  assert_fwd_from_grant_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    fwd_valid |-> $past(evt_grant != '0));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (($past(ovf_flag) & ~ovf_flag) == '0));
endmodule

bind evsem_unit evsem_unit_chk #(
  .NUM_EVT(NUM_EVT), .NUM_SEM(NUM_SEM), .SEM_IW(SEM_IW)
) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .evt_rise(evt_rise), .evt_pend(evt_pend),
  .evt_grant(evt_grant), .rel_valid(rel_valid), .rel_sem(rel_sem),
  .cnt_nz(cnt_nz), .fwd_valid(fwd_valid), .ovf_flag(ovf_flag)
);

// File: tb/evsem_unit_test.sv
module evsem_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] evt_in;
  logic       cfg_we, cfg_remote;
  logic [1:0] cfg_evt, cfg_sem;
  logic [7:0] cfg_units;
  logic       req_valid, req_signal;
  logic [1:0] req_sem;
  logic [3:0] req_task;
  logic       rel_valid, fwd_valid;
  logic [1:0] rel_sem, fwd_sem;
  logic [3:0] rel_task;
  logic [7:0] fwd_units;
  logic [3:0] ovf_flag;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int rel_t[$], rel_s[$], rel_c[$], fwd_s[$], fwd_u[$], fwd_c[$];

  evsem_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_we(cfg_we), .cfg_evt(cfg_evt),
    .cfg_remote(cfg_remote), .cfg_sem(cfg_sem), .cfg_units(cfg_units),
    .req_valid(req_valid), .req_signal(req_signal), .req_sem(req_sem), .req_task(req_task),
    .rel_valid(rel_valid), .rel_sem(rel_sem), .rel_task(rel_task),
    .fwd_valid(fwd_valid), .fwd_sem(fwd_sem), .fwd_units(fwd_units), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (rel_valid) begin rel_t.push_back(rel_task); rel_s.push_back(rel_sem); rel_c.push_back(cyc); end
    if (fwd_valid) begin fwd_s.push_back(fwd_sem); fwd_u.push_back(fwd_units); fwd_c.push_back(cyc); end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clear_logs();
    rel_t.delete(); rel_s.delete(); rel_c.delete();
    fwd_s.delete(); fwd_u.delete(); fwd_c.delete();
  endtask

  task automatic cfg(int e, int rem, int s, int u);
    cfg_we = 1; cfg_evt = 2'(e); cfg_remote = rem[0]; cfg_sem = 2'(s); cfg_units = 8'(u);
    tick(1);
    cfg_we = 0;
  endtask

  task automatic wait_req(int s, int t);
    req_valid = 1; req_signal = 0; req_sem = 2'(s); req_task = 4'(t);
    tick(1);
    req_valid = 0;
  endtask

  task automatic sig_req(int s);
    req_valid = 1; req_signal = 1; req_sem = 2'(s); req_task = 0;
    tick(1);
    req_valid = 0;
  endtask

  task automatic pulse(int e);
    evt_in[e] = 1'b1; tick(2);
    evt_in[e] = 1'b0; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; evt_in = 0; cfg_we = 0; cfg_evt = 0; cfg_remote = 0; cfg_sem = 0;
    cfg_units = 0; req_valid = 0; req_signal = 0; req_sem = 0; req_task = 0;
    tick(3);
    rst_n = 1;
    tick(4);
    // R1 reset state
    chk("R1 rel_valid", rel_valid, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 ovf_flag", ovf_flag, 0);

    // R6/R7/R3: queue of four, fifth dropped, credit 3 units
    cfg(0, 0, 1, 3);
    for (int t = 1; t <= 4; t++) wait_req(1, t);
    wait_req(1, 9);
    tick(3);
    chk("R7 no release without units", rel_t.size(), 0);
    clear_logs();
    pulse(0); tick(6);
    chk("R3 releases from 3 units", rel_t.size(), 3);
    for (int i = 0; i < 3; i++) begin
      if (i < rel_t.size()) begin
        chk("R6 fifo order task", rel_t[i], i + 1);
        chk("R7 release sem", rel_s[i], 1);
      end
    end
    // R9/R7 exact timing of signal release
    sig_req(1);
    chk("R7 release not before next edge", rel_valid, 0);
    tick(1);
    chk("R9 signal release valid", rel_valid, 1);
    chk("R9 signal release task", rel_task, 4);
    tick(2);
    sig_req(1); tick(3);
    chk("R6 dropped task never released", rel_t.size(), 4);
    wait_req(1, 10); tick(3);
    chk("R9 stored unit releases later waiter", rel_t.size(), 5);
    if (rel_t.size() == 5) chk("R9 later waiter task", rel_t[4], 10);

    // R4 remote forwarding with exact latency
    cfg(1, 1, 2, 5);
    clear_logs();
    evt_in[1] = 1'b1;
    tick(4);
    chk("R4 fwd_valid at edge 4", fwd_valid, 1);
    chk("R4 fwd_sem", fwd_sem, 2);
    chk("R4 fwd_units", fwd_units, 5);
    tick(1);
    chk("R4 fwd one cycle", fwd_valid, 0);
    evt_in[1] = 1'b0;
    wait_req(2, 7); tick(8);
    chk("R4 local count untouched", rel_t.size(), 0);
    sig_req(2); tick(3);
    chk("R4 single unit release", rel_t.size(), 1);

    // R5/R2 simultaneous events, ascending order, held level
    cfg(0, 1, 3, 1); cfg(1, 1, 0, 2); cfg(2, 1, 2, 3); cfg(3, 1, 1, 4);
    clear_logs();
    evt_in = 4'hF;
    tick(20);
    chk("R5 four forwards", fwd_s.size(), 4);
    if (fwd_s.size() == 4) begin
      chk("R5 order sem0", fwd_s[0], 3);
      chk("R5 order sem1", fwd_s[1], 0);
      chk("R5 order sem2", fwd_s[2], 2);
      chk("R5 order sem3", fwd_s[3], 1);
      for (int i = 0; i < 4; i++) chk("R5 units by index", fwd_u[i], i + 1);
      chk("R5 one per cycle", fwd_c[3] - fwd_c[0], 3);
    end
    evt_in = 4'h0;
    tick(6);
    chk("R2 falling edge no activity", fwd_s.size(), 4);

    // R8/R9: event credit and signal same edge, different semaphores
    cfg(0, 0, 3, 1);
    wait_req(3, 11); wait_req(0, 12);
    clear_logs();
    evt_in[0] = 1'b1;
    tick(3);
    req_valid = 1; req_signal = 1; req_sem = 0;
    tick(1);
    req_valid = 0; evt_in[0] = 1'b0;
    tick(5);
    chk("R8 two releases", rel_t.size(), 2);
    if (rel_t.size() == 2) begin
      chk("R8 lowest semaphore first", rel_t[0], 12);
      chk("R8 then higher", rel_t[1], 11);
      chk("R8 consecutive", rel_c[1] - rel_c[0], 1);
    end

    // R9: event credit and signal same edge, same semaphore -> 3 units
    cfg(1, 0, 1, 2);
    clear_logs();
    evt_in[1] = 1'b1;
    tick(3);
    req_valid = 1; req_signal = 1; req_sem = 1;
    tick(1);
    req_valid = 0; evt_in[1] = 1'b0;
    tick(3);
    for (int t = 1; t <= 4; t++) wait_req(1, t);
    tick(6);
    chk("R9 combined credit releases", rel_t.size(), 3);

    // R10 saturation boundary
    cfg(2, 0, 2, 255);
    for (int k = 0; k < 257; k++) pulse(2);
    tick(4);
    chk("R10 exactly max no flag", ovf_flag, 0);
    pulse(2); tick(4);
    chk("R10 flag on overflow", ovf_flag, 4);
    sig_req(2); tick(3);
    chk("R10 flag sticky", ovf_flag, 4);
    clear_logs();
    wait_req(2, 13); tick(3);
    chk("R10 release after saturation", rel_t.size(), 1);

    // R1 reset clears flag and counts
    rst_n = 0; tick(2); rst_n = 1; tick(4);
    chk("R1 ovf cleared", ovf_flag, 0);
    clear_logs();
    wait_req(2, 14); tick(6);
    chk("R1 count cleared", rel_t.size(), 0);

    summary();
  end
endmodule